// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block orders the conversions of one shared 12-bit converter across sixteen analog inputs. The inputs form two groups of eight, A and B, and each group has its own sample-and-hold. Software fills a list of 4-bit channel codes, one per slot. It then picks how the list is walked: as one 16-slot list, or split into two 8-slot lists that are started and stopped on their own. Each slot converts a single input, or, in simultaneous mode, the input with the same index in both groups.

For every conversion the block drives the mux select and the sample-and-hold select and raises a request. It waits for the converter's done pulse and stores the 12-bit code left-justified in a 16-bit result register. When the last slot of a list finishes, it sets that list's end-of-sequence flag. The list then either stops or wraps to slot 0 and runs again. Software starts a list by writing a command word, reads results through the same register port, and clears a flag by writing a one to its clear bit.

Register map (word addresses): 0 holds the configuration, 1 takes commands and returns the flags, 16 to 31 hold the slot codes for slots 0 to 15, and 32 to 47 hold the results for indices 0 to 15.

Top module: `adcSeqTop`

## Requirements
- R1: After reset, `convReq` is low and both flags are clear. The configuration word, every slot code and every result read as zero. Configuration bits are 0 dual, 1 simultaneous, 2 continuous, 7:4 last slot of list 0, 11:8 last slot of list 1. The configuration word reads back exactly as written.
- R2: A slot code's bit 3 selects the group (0 = A, 1 = B) and is driven on `shSel`. Its bits 2:0 are driven on `muxSel` during the slot's conversion.
- R3: With dual clear, a start walks slots 0, 1, ... up to the last slot. Each slot's result goes to the result register with the slot's own index.
- R4: With dual set, list 0 uses slots 0 to 7 and results 0 to 7, and list 1 uses slots 8 to 15 and results 8 to 15. Only the low three bits of each last-slot field are used. When both lists want the converter, list 0 is served first at each conversion boundary.
- R5: A last-slot field holds the slot count minus one. The values 0 and 15 give one slot and sixteen slots.
- R6: In simultaneous mode each slot performs two conversions on the same `muxSel` index: group A first, then group B, whatever the value of code bit 3. Slot k writes result base+2k (A) and base+2k+1 (B).
- R7: A result register holds the 12-bit code in bits 15:4, and bits 3:0 read as zero.
- R8: The flag of a list (flag bit 0 = list 0, bit 1 = list 1, also on `eosFlag`) sets when its last conversion completes. Writing a one to command bit 2 (list 0) or bit 3 (list 1) clears only that flag.
- R9: With continuous clear, a list stops after one pass and `convReq` stays low. With continuous set, it returns to slot 0 after the last slot and goes on without a new start.
- R10: Command bit 0 starts list 0 and bit 1 starts list 1. A start to a list that is already running is ignored. A start to list 1 is ignored while dual is clear.
- R11: Command bit 4 (list 0) or bit 5 (list 1) stops the list and returns its pointer to slot 0. No further conversion is requested until a new start, which begins at slot 0.
- R12: `convReq` and the selects stay steady until `convDone` arrives. A `convDone` pulse while no request is pending changes no result and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address for writes and reads |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for `regAddr` (combinational) |
| convReq | output | 1 | Conversion request to the converter |
| muxSel | output | 3 | Input index within the selected group |
| shSel | output | 1 | Sample-and-hold group select, 0 = A, 1 = B |
| convDone | input | 1 | One-cycle pulse: conversion finished |
| convData | input | 12 | Converted code, valid with `convDone` |
| eosFlag | output | 2 | End-of-sequence flags of list 0 and list 1 |

## Verification
The bench builds the block with its defaults: sixteen slots, a 12-bit converter and 16-bit results. With these values the full-length list (last slot 15) can be reached, and the dual split falls exactly at slot 8. A behavioural converter answers each request after a latency of one to three cycles. It logs the selects it saw and returns a code made from the conversion number. This lets the bench recompute the expected order, the group and input of each slot, and the result index under random codes and lengths. The same log shows whether starts are ignored, whether continuous mode wraps, and that nothing runs after a sequencer reset.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;
  localparam int unsigned PKG_IDX_W = 4;
  localparam int unsigned PKG_RAW_W = 12;
  localparam int unsigned PKG_REG_W = 16;

  // control -> datapath strobes
  typedef struct packed {
    logic                 resWr;
    logic [PKG_IDX_W-1:0] resIdx;
    logic [PKG_RAW_W-1:0] resRaw;
    logic [1:0]           eosSet;
  } seqStrobe_t;

  // datapath -> control decoded commands
  typedef struct packed {
    logic [1:0] go;
    logic [1:0] rst;
  } seqCmd_t;

  // configuration fields
  typedef struct packed {
    logic                 dual;
    logic                 simul;
    logic                 cont;
    logic [PKG_IDX_W-1:0] lastA;
    logic [PKG_IDX_W-1:0] lastB;
  } seqCfg_t;
endpackage

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcSeqPkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned RAW_W     = 12,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [REG_W-1:0]              regWrData,
  output logic [REG_W-1:0]              regRdData,
  input  seqStrobe_t                    strobe,
  output seqCmd_t                       cmd,
  output seqCfg_t                       cfg,
  output logic [NUM_SLOTS-1:0][3:0]     slotCode,
  output logic [1:0]                    eosFlag
);
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);
  localparam int unsigned REGN_W = ADDR_W - SLOT_W;
  localparam int unsigned JUST   = REG_W - RAW_W;
  localparam logic [REGN_W-1:0] REGN_CTL  = REGN_W'(0);
  localparam logic [REGN_W-1:0] REGN_CODE = REGN_W'(1);
  localparam logic [REGN_W-1:0] REGN_RES  = REGN_W'(2);

  logic [REGN_W-1:0] region;
  logic [SLOT_W-1:0] sub;
  logic              cfgWr, cmdWr;
  logic [REG_W-1:0]  cfgQ;
  logic [3:0]        codeQ   [NUM_SLOTS];
  logic [REG_W-1:0]  resultQ [NUM_SLOTS];
  logic [1:0]        flagQ;
  logic [1:0]        clrReq;

  assign region = regAddr[ADDR_W-1:SLOT_W];
  assign sub    = regAddr[SLOT_W-1:0];
  assign cfgWr  = regWrEn && (region == REGN_CTL) && (sub == SLOT_W'(0));
  assign cmdWr  = regWrEn && (region == REGN_CTL) && (sub == SLOT_W'(1));

  assign cmd.go  = cmdWr ? regWrData[1:0] : 2'b00;
  assign cmd.rst = cmdWr ? regWrData[5:4] : 2'b00;
  assign clrReq  = cmdWr ? regWrData[3:2] : 2'b00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgWr) cfgQ <= regWrData;
  end

  assign cfg.dual  = cfgQ[0];
  assign cfg.simul = cfgQ[1];
  assign cfg.cont  = cfgQ[2];
  assign cfg.lastA = cfgQ[4 +: SLOT_W];
  assign cfg.lastB = cfgQ[8 +: SLOT_W];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        codeQ[g] <= '0;
      else if (regWrEn && region == REGN_CODE && sub == SLOT_W'(g))
        codeQ[g] <= regWrData[3:0];
    end
    assign slotCode[g] = codeQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        resultQ[g] <= '0;
      else if (strobe.resWr && strobe.resIdx == SLOT_W'(g))
        resultQ[g] <= {strobe.resRaw, {JUST{1'b0}}};
    end
  end

  for (genvar s = 0; s < 2; s++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                flagQ[s] <= 1'b0;
      else if (strobe.eosSet[s]) flagQ[s] <= 1'b1;
      else if (clrReq[s])        flagQ[s] <= 1'b0;
    end
  end
  assign eosFlag = flagQ;

  always_comb begin
    regRdData = '0;
    unique case (region)
      REGN_CTL: begin
        if (sub == SLOT_W'(0))      regRdData = cfgQ;
        else if (sub == SLOT_W'(1)) regRdData[1:0] = flagQ;
      end
      REGN_CODE: regRdData[3:0] = codeQ[sub];
      REGN_RES:  regRdData = resultQ[sub];
      default:   regRdData = '0;
    endcase
  end

  // R7: result words never carry data in the low bits
  a_r7_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (region == REGN_RES) |-> (regRdData[JUST-1:0] == '0));
  // R8: flag follows the end-of-sequence strobe
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eosSet[0] |=> eosFlag[0]);
  // R8: clear by writing one, when no set competes
  a_r8_flag_clr: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWrData[2] && !strobe.eosSet[0]) |=> !eosFlag[0]);
endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned RAW_W     = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqCfg_t                   cfg,
  input  seqCmd_t                   cmd,
  input  logic [NUM_SLOTS-1:0][3:0] slotCode,
  input  logic                      convDone,
  input  logic [RAW_W-1:0]          convData,
  output logic                      convReq,
  output logic [2:0]                muxSel,
  output logic                      shSel,
  output seqStrobe_t                strobe
);
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);
  localparam int unsigned HALF   = NUM_SLOTS / 2;
  localparam logic [SLOT_W-1:0] HALF_MASK = SLOT_W'(HALF - 1);

  logic [1:0]             busyQ;
  logic [1:0][SLOT_W-1:0] ptrQ;
  logic [1:0]             phaseQ;
  logic                   inConvQ;
  logic                   ownerQ;

  logic [1:0][SLOT_W-1:0] lastEff;
  logic [SLOT_W-1:0]      baseSel, curSlot, curPtr, resIdx;
  logic [3:0]             code;
  logic                   curPhase, hit, lastHit;

  assign lastEff[0] = cfg.dual ? (cfg.lastA & HALF_MASK) : cfg.lastA;
  assign lastEff[1] = cfg.lastB & HALF_MASK;

  assign baseSel  = ownerQ ? SLOT_W'(HALF) : '0;
  assign curPtr   = ptrQ[ownerQ];
  assign curPhase = phaseQ[ownerQ];
  assign curSlot  = baseSel + curPtr;
  assign code     = slotCode[curSlot];

  assign convReq = inConvQ;
  assign muxSel  = code[2:0];
  assign shSel   = cfg.simul ? curPhase : code[3];

  assign hit     = inConvQ && convDone;
  assign lastHit = (curPtr == lastEff[ownerQ]) && (!cfg.simul || curPhase);
  assign resIdx  = cfg.simul ? baseSel + {curPtr[SLOT_W-2:0], curPhase} : curSlot;

  always_comb begin
    strobe        = '0;
    strobe.resWr  = hit;
    strobe.resIdx = resIdx;
    strobe.resRaw = convData;
    strobe.eosSet[ownerQ] = hit && lastHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= '0;
      ptrQ    <= '0;
      phaseQ  <= '0;
      inConvQ <= 1'b0;
      ownerQ  <= 1'b0;
    end else begin
      // advance the owning list on a completed conversion
      if (hit) begin
        if (cfg.simul && !curPhase) begin
          phaseQ[ownerQ] <= 1'b1;
        end else begin
          phaseQ[ownerQ] <= 1'b0;
          if (lastHit) begin
            ptrQ[ownerQ]  <= '0;
            busyQ[ownerQ] <= cfg.cont;
          end else begin
            ptrQ[ownerQ] <= curPtr + SLOT_W'(1);
          end
        end
      end
      // starts and sequencer resets
      for (int s = 0; s < 2; s++) begin
        if (cmd.rst[s]) begin
          busyQ[s]  <= 1'b0;
          ptrQ[s]   <= '0;
          phaseQ[s] <= 1'b0;
        end else if (cmd.go[s] && !busyQ[s] && (s == 0 || cfg.dual)) begin
          busyQ[s]  <= 1'b1;
          ptrQ[s]   <= '0;
          phaseQ[s] <= 1'b0;
        end
      end
      // converter ownership, list 0 first
      if (inConvQ) begin
        if (hit || cmd.rst[ownerQ]) inConvQ <= 1'b0;
      end else if (busyQ[0] && !cmd.rst[0]) begin
        inConvQ <= 1'b1;
        ownerQ  <= 1'b0;
      end else if (busyQ[1] && !cmd.rst[1]) begin
        inConvQ <= 1'b1;
        ownerQ  <= 1'b1;
      end
    end
  end

  // R12: request and selects steady while waiting for the converter
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (inConvQ && !convDone && cmd.rst == 2'b00) |=> (convReq && $stable(muxSel) && $stable(shSel)));
  // R5: pointer stays inside the programmed length
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    busyQ[0] |-> (ptrQ[0] <= lastEff[0]));
  // R4: second list only runs in dual mode
  a_r4_dual_only: assert property (@(posedge clk) disable iff (!rstN)
    busyQ[1] |-> cfg.dual);
  // R10: a start to a running list leaves its pointer alone
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ[0] && cmd.go[0] && !cmd.rst[0] && !hit) |=> $stable(ptrQ[0]));
  // R11: sequencer reset stops the list at slot 0
  a_r11_seq_rst: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rst[0] |=> (!busyQ[0] && ptrQ[0] == '0));
endmodule

// File: rtl/adcSeqTop.sv
module adcSeqTop
  import adcSeqPkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned RAW_W     = 12,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              convReq,
  output logic [2:0]        muxSel,
  output logic              shSel,
  input  logic              convDone,
  input  logic [RAW_W-1:0]  convData,
  output logic [1:0]        eosFlag
);
  seqStrobe_t                strobe;
  seqCmd_t                   cmd;
  seqCfg_t                   cfg;
  logic [NUM_SLOTS-1:0][3:0] slotCode;

  adcSeqData #(
    .NUM_SLOTS(NUM_SLOTS), .RAW_W(RAW_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) uData (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .cmd(cmd), .cfg(cfg), .slotCode(slotCode), .eosFlag(eosFlag)
  );

  adcSeqCtrl #(
    .NUM_SLOTS(NUM_SLOTS), .RAW_W(RAW_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .cmd(cmd), .slotCode(slotCode),
    .convDone(convDone), .convData(convData), .convReq(convReq),
    .muxSel(muxSel), .shSel(shSel), .strobe(strobe)
  );
endmodule

// File: tb/test_adcSeqTop.sv
module test_adcSeqTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        convReq;
  logic [2:0]  muxSel;
  logic        shSel;
  logic        convDone;
  logic        modelDone = 1'b0;
  logic        spurDone = 1'b0;
  logic [11:0] convData = '0;
  logic [1:0]  eosFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int logCount = 0;
  bit   logSh   [0:1023];
  int   logMux  [0:1023];
  int   logData [0:1023];
  logic [3:0] codes [16];

  always #5 clk = ~clk;
  assign convDone = modelDone | spurDone;

  adcSeqTop i_adcSeqTop (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .convReq(convReq),
    .muxSel(muxSel), .shSel(shSel), .convDone(convDone),
    .convData(convData), .eosFlag(eosFlag)
  );

  // behavioural converter: variable latency, logs what it was asked to sample
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (modelDone) begin
        modelDone = 1'b0;
        cnt = 0;
      end else if (convReq) begin
        cnt++;
        if (cnt >= 1 + (logCount % 3)) begin
          logSh[logCount % 1024]   = shSel;
          logMux[logCount % 1024]  = int'(muxSel);
          convData = 12'((logCount * 613 + int'(shSel) * 1031 + int'(muxSel) * 97 + 11) & 12'hfff);
          logData[logCount % 1024] = int'(convData);
          logCount++;
          modelDone = 1'b1;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = 6'(addr);
    regWrData = 16'(data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    regAddr = 6'(addr);
    #1;
    data = int'(regRdData);
  endtask

  function automatic int mkCfg(bit dual, bit simul, bit cont, int lastA, int lastB);
    return int'(dual) | (int'(simul) << 1) | (int'(cont) << 2) | ((lastA & 15) << 4) | ((lastB & 15) << 8);
  endfunction

  task automatic waitLog(input int n);
    int guard = 0;
    while (logCount < n && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (logCount < n) chk("R9 conversions not reached", logCount, n);
  endtask

  task automatic waitFlag(input int s);
    int guard = 0;
    while (!eosFlag[s] && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk("R8 flag raised", int'(eosFlag[s]), 1);
  endtask

  task automatic loadCodes();
    for (int i = 0; i < 16; i++) begin
      codes[i] = 4'($urandom);
      wr(16 + i, int'(codes[i]));
    end
  endtask

  // one-shot pass on list 0 in cascaded mode, checked slot by slot
  task automatic casPass(input int last, input bit simul);
    int start, n, v;
    loadCodes();
    wr(0, mkCfg(0, simul, 0, last, 0));
    wr(1, 32'h0c);
    start = logCount;
    wr(1, 1);
    waitFlag(0);
    repeat (6) @(negedge clk);
    chk("R9 one-shot stops", int'(convReq), 0);
    n = simul ? 2 * (last + 1) : last + 1;
    chk("R5 conversion count", logCount - start, n);
    for (int k = 0; k < n; k++) begin
      int slot = simul ? k / 2 : k;
      int idx  = simul ? k : slot;
      int expSh = simul ? (k % 2) : int'(codes[slot][3]);
      if (simul) chk("R6 pair group order", int'(logSh[start + k]), expSh);
      else       chk("R2 group select", int'(logSh[start + k]), expSh);
      chk("R2 input select", logMux[start + k], int'(codes[slot][2:0]));
      rd(32 + idx, v);
      if (simul) chk("R6 pair result index", v, logData[start + k] << 4);
      else       chk("R3 R7 result at slot index", v, logData[start + k] << 4);
    end
  endtask

  initial begin
    int v, mark;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 convReq idle", int'(convReq), 0);
    chk("R1 flags clear", int'(eosFlag), 0);
    rd(0, v);  chk("R1 config zero", v, 0);
    rd(19, v); chk("R1 slot code zero", v, 0);
    rd(37, v); chk("R1 result zero", v, 0);
    wr(0, 16'hfff6);
    rd(0, v);  chk("R1 config readback", v, 16'hfff6);

    // R3 random cascaded sequential passes
    for (int p = 0; p < 4; p++) casPass(int'($urandom % 16), 1'b0);
    // R5 boundary lengths
    casPass(15, 1'b0);
    casPass(0, 1'b0);
    // R6 simultaneous passes
    casPass(3, 1'b1);
    casPass(int'($urandom % 8), 1'b1);

    // R4 dual mode, both started at once, masked last fields (10 -> 2, 9 -> 1)
    loadCodes();
    wr(0, mkCfg(1, 0, 0, 10, 9));
    wr(1, 32'h0c);
    mark = logCount;
    wr(1, 3);
    waitFlag(0);
    waitFlag(1);
    repeat (6) @(negedge clk);
    chk("R4 dual conversion count", logCount - mark, 5);
    begin
      int expSlot [5] = '{0, 1, 2, 8, 9};
      for (int k = 0; k < 5; k++) begin
        chk("R4 dual order mux", logMux[mark + k], int'(codes[expSlot[k]][2:0]));
        chk("R4 dual order group", int'(logSh[mark + k]), int'(codes[expSlot[k]][3]));
        rd(32 + expSlot[k], v);
        chk("R4 dual result index", v, logData[mark + k] << 4);
      end
    end
    // R8 clearing one flag leaves the other
    wr(1, 4);
    chk("R8 clear only flag 0", int'(eosFlag), 2);
    wr(1, 8);
    chk("R8 clear flag 1", int'(eosFlag), 0);

    // R10 start to list 1 ignored in cascaded mode
    wr(0, mkCfg(0, 0, 0, 3, 3));
    mark = logCount;
    wr(1, 2);
    repeat (20) @(negedge clk);
    chk("R10 list1 start ignored", logCount - mark, 0);
    chk("R10 list1 flag stays", int'(eosFlag[1]), 0);

    // R10 restart while running is ignored
    loadCodes();
    wr(0, mkCfg(0, 0, 0, 5, 0));
    mark = logCount;
    wr(1, 1);
    waitLog(mark + 2);
    wr(1, 1);
    waitFlag(0);
    repeat (6) @(negedge clk);
    chk("R10 restart ignored count", logCount - mark, 6);
    for (int k = 0; k < 6; k++)
      chk("R10 order kept", logMux[mark + k], int'(codes[k][2:0]));
    wr(1, 4);

    // R9 continuous wrap, R11 sequencer reset
    wr(0, mkCfg(0, 0, 1, 2, 0));
    mark = logCount;
    wr(1, 1);
    waitLog(mark + 10);
    chk("R8 flag in continuous run", int'(eosFlag[0]), 1);
    for (int k = 0; k < 10; k++)
      chk("R9 wrap order", logMux[mark + k], int'(codes[k % 3][2:0]));
    wr(1, 32'h10);
    @(negedge clk);
    mark = logCount;
    repeat (15) @(negedge clk);
    chk("R11 stopped request", int'(convReq), 0);
    chk("R11 no conversions after reset", logCount - mark, 0);
    wr(0, mkCfg(0, 0, 0, 1, 0));
    wr(1, 32'h0c);
    mark = logCount;
    wr(1, 1);
    waitFlag(0);
    chk("R11 restart count", logCount - mark, 2);
    chk("R11 restart at slot 0", logMux[mark], int'(codes[0][2:0]));
    chk("R11 then slot 1", logMux[mark + 1], int'(codes[1][2:0]));

    // R12 stray done while idle
    repeat (4) @(negedge clk);
    wr(1, 32'h0c);
    rd(32, mark);
    @(negedge clk);
    spurDone = 1'b1;
    @(negedge clk);
    spurDone = 1'b0;
    @(negedge clk);
    rd(32, v);
    chk("R12 stray done no write", v, mark);
    chk("R12 stray done no flag", int'(eosFlag), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule